// File: doc/BRIEF.md
# Pseudo-Sync Pulse Window Detector

This block watches the active-low sync stream of a decoded video signal and looks for the short, narrow sync-like pulses that analogue copy-protection schemes insert in the vertical blanking interval. A field-start strobe resets a line counter. Every sync pulse that is wide enough to be a real horizontal sync advances that counter. Every narrower pulse is measured in pixel clocks. A narrow pulse counts as a pseudo-sync pulse when its width falls inside a programmable band and it sits on a line inside a programmable window.

When the last line of the window ends, the block decides whether protection is present and updates a held detected flag. In standard-definition mode the decision uses a selectable quota of pulses seen on the final three lines of the window. In progressive mode it uses the total for the window. A running count of qualified pulses in the current field is also given. The line and width limits come either from built-in presets, chosen by scan mode and line standard, or from configuration ports. An oversample flag lets the block run at twice the nominal pixel rate.

Top module: `pseudo_sync_detector`

## Requirements
- R1: After reset, `detected` is 0 and `pulse_count` is 0.
- R2: A low pulse on `sync_n` is measured as the number of clocks it stays low. A measured width below 24 is a candidate pseudo pulse, and it qualifies only if min <= width <= max (both bounds inclusive).
- R3: The line number is 0 after `field_start`. It advances by one at the end of each low pulse whose measured width is 24 or more (a line sync), and such a pulse is never counted as a pseudo pulse. Only candidate pulses that end on a line from the window start to the window end, inclusive, are counted.
- R4: With `cfg_oversample` = 1, the measured width has its LSB dropped (it is halved) before every comparison, including the line-sync threshold.
- R5: With `cfg_use_regs` = 0, the limits are presets. Standard-definition NTSC uses lines 13..21 and widths 6..9. Standard-definition PAL (`cfg_pal` = 1) uses lines 8..16 and widths 6..9. Progressive (`cfg_progressive` = 1, whatever `cfg_pal` is) uses lines 12..20 and widths 6..9. With `cfg_use_regs` = 1, the limit ports are used.
- R6: In standard-definition mode the decision is true when the pulses counted on lines end-2..end (inside the window) reach the quota. `cfg_quota_sel` encodes the quota as 00=6, 01=4, 10=5, 11=7.
- R7: In progressive mode the decision is true when the field's qualified-pulse count is at least 4, and `cfg_quota_sel` has no effect.
- R8: `detected` takes the decision only at the clock that handles the end of a line sync starting on the window end line. It holds its value at all other times, including across `field_start`.
- R9: `field_start` clears the line number and the pulse counts, so `pulse_count` reads 0 on the following cycle. `pulse_count` otherwise never decreases.
- R10: The width counter saturates at 255 instead of wrapping, so a very long low pulse still counts as a line sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_n | input | 1 | Decoded composite sync, active low |
| field_start | input | 1 | One-cycle strobe at the start of each field |
| cfg_width_max | input | 4 | Programmed largest accepted pulse width |
| cfg_width_min | input | 4 | Programmed smallest accepted pulse width |
| cfg_line_first | input | 6 | Programmed first line of the window |
| cfg_line_last | input | 6 | Programmed last line of the window |
| cfg_oversample | input | 1 | 1 = clock runs at twice the nominal rate |
| cfg_progressive | input | 1 | 0 = standard definition, 1 = progressive |
| cfg_pal | input | 1 | 1 = PAL timing in standard definition |
| cfg_use_regs | input | 1 | 0 = presets, 1 = programmed limits |
| cfg_quota_sel | input | 2 | Tail-line pulse quota code |
| detected | output | 1 | Held protection-present decision |
| pulse_count | output | 8 | Qualified pulses in the current field |

## Verification
The assertions assume that `field_start` is a single-cycle strobe and that configuration stays still while a field is being processed. They also assume the window end line is actually reached by line syncs before the next strobe; otherwise the flag simply holds. The stimulus changes configuration only between fields, drives `sync_n` with low pulses separated by at least three high clocks, and ends every field with a line sync on the window end line. Pseudo pulses always stay well below the line-sync threshold, except in the saturation test.

// File: rtl/pseudo_sync_pkg.sv
package pseudo_sync_pkg;

  typedef struct packed {
    logic [5:0] line_first;
    logic [5:0] line_last;
    logic [3:0] width_min;
    logic [3:0] width_max;
  } win_limits_t;

  function automatic logic [2:0] quota_from_code(input logic [1:0] code);
    case (code)
      2'b00:   quota_from_code = 3'd6;
      2'b01:   quota_from_code = 3'd4;
      2'b10:   quota_from_code = 3'd5;
      default: quota_from_code = 3'd7;
    endcase
  endfunction

endpackage

// File: rtl/ps_width_meter.sv
module ps_width_meter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_n,
  input  logic             oversample,
  output logic             pulse_end,
  output logic [CNT_W-1:0] width_eff
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             sync_q1, sync_q2;
  logic [CNT_W-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q1 <= 1'b1;
      sync_q2 <= 1'b1;
      low_cnt <= '0;
    end else begin
      sync_q1 <= sync_n;
      sync_q2 <= sync_q1;
      if (!sync_q1) begin
        if (low_cnt != CNT_MAX) low_cnt <= low_cnt + 1'b1;
      end else begin
        low_cnt <= '0;
      end
    end
  end

  assign pulse_end = sync_q1 & ~sync_q2;
  assign width_eff = oversample ? (low_cnt >> 1) : low_cnt;

  assert_end_single_R2: assert property (@(posedge clk) disable iff (rst)
    pulse_end |=> !pulse_end);

  assert_no_wrap_R10: assert property (@(posedge clk) disable iff (rst)
    !sync_q1 |=> (low_cnt != '0));

endmodule

// File: rtl/ps_limit_select.sv
module ps_limit_select
  import pseudo_sync_pkg::*;
#(
  parameter int NTSC_FIRST = 13,
  parameter int NTSC_LAST  = 21,
  parameter int PAL_FIRST  = 8,
  parameter int PAL_LAST   = 16,
  parameter int PROG_FIRST = 12,
  parameter int PROG_LAST  = 20,
  parameter int PRE_WMIN   = 6,
  parameter int PRE_WMAX   = 9
) (
  input  logic        use_regs,
  input  logic        progressive,
  input  logic        pal,
  input  logic [1:0]  quota_sel,
  input  win_limits_t prog_limits,
  output win_limits_t limits,
  output logic [2:0]  quota
);
  win_limits_t preset;

  always_comb begin
    preset.width_min = 4'(PRE_WMIN);
    preset.width_max = 4'(PRE_WMAX);
    if (progressive) begin
      preset.line_first = 6'(PROG_FIRST);
      preset.line_last  = 6'(PROG_LAST);
    end else if (pal) begin
      preset.line_first = 6'(PAL_FIRST);
      preset.line_last  = 6'(PAL_LAST);
    end else begin
      preset.line_first = 6'(NTSC_FIRST);
      preset.line_last  = 6'(NTSC_LAST);
    end
    limits = use_regs ? prog_limits : preset;
    quota  = quota_from_code(quota_sel);
  end

endmodule

// File: rtl/ps_window_counter.sv
module ps_window_counter
  import pseudo_sync_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int LINE_W    = 6,
  parameter int COUNT_W   = 8,
  parameter int LSYNC_MIN = 24,
  parameter int PROG_MIN  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               field_start,
  input  logic               pulse_end,
  input  logic [CNT_W-1:0]   width_eff,
  input  win_limits_t        limits,
  input  logic [2:0]         quota,
  input  logic               progressive,
  output logic               detected,
  output logic [COUNT_W-1:0] field_count
);
  localparam logic [LINE_W-1:0]  LINE_MAX  = '1;
  localparam logic [COUNT_W-1:0] COUNT_MAX = '1;

  logic [LINE_W-1:0]  line_no;
  logic [COUNT_W-1:0] tail_count;
  logic               line_sync, width_ok, in_window, in_tail, boundary, decision;

  always_comb begin
    line_sync = width_eff >= CNT_W'(LSYNC_MIN);
    width_ok  = (width_eff >= CNT_W'(limits.width_min)) &&
                (width_eff <= CNT_W'(limits.width_max));
    in_window = (line_no >= limits.line_first) && (line_no <= limits.line_last);
    in_tail   = in_window &&
                (({1'b0, line_no} + 7'd2) >= {1'b0, limits.line_last});
    boundary  = pulse_end && line_sync && (line_no == limits.line_last);
    decision  = progressive ? (field_count >= COUNT_W'(PROG_MIN))
                            : (tail_count >= COUNT_W'(quota));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_no     <= '0;
      field_count <= '0;
      tail_count  <= '0;
      detected    <= 1'b0;
    end else if (field_start) begin
      line_no     <= '0;
      field_count <= '0;
      tail_count  <= '0;
    end else if (pulse_end) begin
      if (line_sync) begin
        if (line_no != LINE_MAX) line_no <= line_no + 1'b1;
        if (boundary) detected <= decision;
      end else if (width_ok && in_window) begin
        if (field_count != COUNT_MAX) field_count <= field_count + 1'b1;
        if (in_tail && tail_count != COUNT_MAX) tail_count <= tail_count + 1'b1;
      end
    end
  end

  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    field_start |=> (field_count == '0));

  assert_monotonic_R9: assert property (@(posedge clk) disable iff (rst)
    !field_start |=> (field_count >= $past(field_count)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(detected));

  assert_line_step_R3: assert property (@(posedge clk) disable iff (rst)
    (!field_start && !(pulse_end && line_sync)) |=> $stable(line_no));

  assert_tail_bound_R6: assert property (@(posedge clk) disable iff (rst)
    tail_count <= field_count);

endmodule

// File: rtl/pseudo_sync_detector.sv
module pseudo_sync_detector
  import pseudo_sync_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int LINE_W    = 6,
  parameter int COUNT_W   = 8,
  parameter int LSYNC_MIN = 24,
  parameter int PROG_MIN  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sync_n,
  input  logic               field_start,
  input  logic [3:0]         cfg_width_max,
  input  logic [3:0]         cfg_width_min,
  input  logic [5:0]         cfg_line_first,
  input  logic [5:0]         cfg_line_last,
  input  logic               cfg_oversample,
  input  logic               cfg_progressive,
  input  logic               cfg_pal,
  input  logic               cfg_use_regs,
  input  logic [1:0]         cfg_quota_sel,
  output logic               detected,
  output logic [COUNT_W-1:0] pulse_count
);
  logic             pulse_end;
  logic [CNT_W-1:0] width_eff;
  win_limits_t      prog_limits, limits;
  logic [2:0]       quota;

  assign prog_limits = '{line_first: cfg_line_first, line_last: cfg_line_last,
                         width_min: cfg_width_min, width_max: cfg_width_max};

  ps_width_meter #(.CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst(rst), .sync_n(sync_n), .oversample(cfg_oversample),
    .pulse_end(pulse_end), .width_eff(width_eff));

  ps_limit_select u_limits (
    .use_regs(cfg_use_regs), .progressive(cfg_progressive), .pal(cfg_pal),
    .quota_sel(cfg_quota_sel), .prog_limits(prog_limits),
    .limits(limits), .quota(quota));

  ps_window_counter #(
    .CNT_W(CNT_W), .LINE_W(LINE_W), .COUNT_W(COUNT_W),
    .LSYNC_MIN(LSYNC_MIN), .PROG_MIN(PROG_MIN)
  ) u_window (
    .clk(clk), .rst(rst), .field_start(field_start), .pulse_end(pulse_end),
    .width_eff(width_eff), .limits(limits), .quota(quota),
    .progressive(cfg_progressive), .detected(detected), .field_count(pulse_count));

endmodule

// File: tb/test_pseudo_sync_detector.sv
module test_pseudo_sync_detector;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sync_n = 1'b1;
  logic       field_start = 1'b0;
  logic [3:0] cfg_width_max = 4'd0, cfg_width_min = 4'd0;
  logic [5:0] cfg_line_first = 6'd0, cfg_line_last = 6'd0;
  logic       cfg_oversample = 1'b0, cfg_progressive = 1'b0, cfg_pal = 1'b0;
  logic       cfg_use_regs = 1'b0;
  logic [1:0] cfg_quota_sel = 2'b10;
  logic       detected;
  logic [7:0] pulse_count;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pseudo_sync_detector i_pseudo_sync_detector (
    .clk(clk), .rst(rst), .sync_n(sync_n), .field_start(field_start),
    .cfg_width_max(cfg_width_max), .cfg_width_min(cfg_width_min),
    .cfg_line_first(cfg_line_first), .cfg_line_last(cfg_line_last),
    .cfg_oversample(cfg_oversample), .cfg_progressive(cfg_progressive),
    .cfg_pal(cfg_pal), .cfg_use_regs(cfg_use_regs), .cfg_quota_sel(cfg_quota_sel),
    .detected(detected), .pulse_count(pulse_count));

  typedef struct packed {
    logic       use_regs, prog, pal, os;
    logic [1:0] qsel;
    logic [3:0] wmin, wmax;
    logic [5:0] first, last;
    logic [8:0] width;
    logic [3:0] per_line;
    logic [5:0] end_line;
    logic [7:0] exp_count;
    logic       exp_det;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0,1'b0,1'b0,1'b0,2'b10,4'd0,4'd0,6'd0,6'd0,   9'd7, 4'd2,6'd21,8'd18,1'b1},
    '{1'b0,1'b0,1'b0,1'b0,2'b10,4'd0,4'd0,6'd0,6'd0,   9'd10,4'd2,6'd21,8'd0, 1'b0},
    '{1'b0,1'b0,1'b0,1'b0,2'b10,4'd0,4'd0,6'd0,6'd0,   9'd5, 4'd2,6'd21,8'd0, 1'b0},
    '{1'b0,1'b0,1'b0,1'b0,2'b10,4'd0,4'd0,6'd0,6'd0,   9'd6, 4'd1,6'd21,8'd9, 1'b0},
    '{1'b0,1'b0,1'b0,1'b0,2'b11,4'd0,4'd0,6'd0,6'd0,   9'd9, 4'd2,6'd21,8'd18,1'b0},
    '{1'b0,1'b0,1'b0,1'b0,2'b01,4'd0,4'd0,6'd0,6'd0,   9'd9, 4'd2,6'd21,8'd18,1'b1},
    '{1'b1,1'b0,1'b0,1'b0,2'b00,4'd3,4'd4,6'd5,6'd10,  9'd4, 4'd3,6'd10,8'd18,1'b1},
    '{1'b1,1'b0,1'b0,1'b1,2'b10,4'd6,4'd9,6'd13,6'd21, 9'd14,4'd2,6'd21,8'd18,1'b1},
    '{1'b1,1'b0,1'b0,1'b1,2'b10,4'd6,4'd9,6'd13,6'd21, 9'd20,4'd2,6'd21,8'd0, 1'b0},
    '{1'b0,1'b1,1'b0,1'b0,2'b11,4'd0,4'd0,6'd0,6'd0,   9'd8, 4'd1,6'd20,8'd9, 1'b1},
    '{1'b0,1'b1,1'b0,1'b0,2'b11,4'd0,4'd0,6'd0,6'd0,   9'd12,4'd1,6'd20,8'd0, 1'b0},
    '{1'b0,1'b0,1'b1,1'b0,2'b10,4'd0,4'd0,6'd0,6'd0,   9'd7, 4'd2,6'd16,8'd18,1'b1},
    '{1'b1,1'b0,1'b0,1'b0,2'b01,4'd6,4'd9,6'd10,6'd11, 9'd7, 4'd3,6'd11,8'd6, 1'b1}
  };

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic low_pulse(input int width);
    sync_n = 1'b0;
    repeat (width) @(negedge clk);
    sync_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic strobe_field();
    field_start = 1'b1;
    @(negedge clk);
    field_start = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_field(input int width, input int per_line, input int end_line, input bit os);
    strobe_field();
    for (int ln = 0; ln <= end_line; ln++) begin
      for (int p = 0; p < per_line; p++) low_pulse(width);
      low_pulse(os ? 80 : 40);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 detected after reset", int'(detected), 0);
    check("R1 count after reset", int'(pulse_count), 0);

    for (int i = 0; i < NVEC; i++) begin
      cfg_use_regs    = VECS[i].use_regs;
      cfg_progressive = VECS[i].prog;
      cfg_pal         = VECS[i].pal;
      cfg_oversample  = VECS[i].os;
      cfg_quota_sel   = VECS[i].qsel;
      cfg_width_min   = VECS[i].wmin;
      cfg_width_max   = VECS[i].wmax;
      cfg_line_first  = VECS[i].first;
      cfg_line_last   = VECS[i].last;
      @(negedge clk);
      run_field(int'(VECS[i].width), int'(VECS[i].per_line), int'(VECS[i].end_line), VECS[i].os);
      // R2 R3 R4 R5 band, window, oversample, presets; R6 R7 decisions
      check($sformatf("R2/R3/R4/R5 vector %0d count", i), int'(pulse_count), int'(VECS[i].exp_count));
      check($sformatf("R6/R7/R8 vector %0d detected", i), int'(detected), int'(VECS[i].exp_det));
    end

    // R9 and R8: field strobe clears count, flag holds
    strobe_field();
    check("R9 count cleared by field_start", int'(pulse_count), 0);
    check("R8 detected held across field_start", int'(detected), 1);

    // R10: a 263-clock low pulse must saturate and act as a line sync
    cfg_use_regs = 1'b1; cfg_progressive = 1'b0; cfg_oversample = 1'b0;
    cfg_width_min = 4'd6; cfg_width_max = 4'd9;
    cfg_line_first = 6'd1; cfg_line_last = 6'd1; cfg_quota_sel = 2'b01;
    @(negedge clk);
    strobe_field();
    low_pulse(263);
    low_pulse(7);
    repeat (4) @(negedge clk);
    check("R10 saturated pulse advanced the line", int'(pulse_count), 1);
    check("R8 no boundary yet, flag held", int'(detected), 1);
    low_pulse(40);
    repeat (4) @(negedge clk);
    check("R6 quota 4 not met on one pulse", int'(detected), 0);

    // R4: odd oversampled width 19 halves to 9, still in band
    cfg_oversample = 1'b1;
    @(negedge clk);
    strobe_field();
    low_pulse(80);
    low_pulse(19);
    low_pulse(21);
    repeat (4) @(negedge clk);
    check("R4 odd widths 19 and 21 halved", int'(pulse_count), 1);

    // R1: reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 count after late reset", int'(pulse_count), 0);
    check("R1 detected after late reset", int'(detected), 0);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule